// File: doc/BRIEF.md
# Page-Bounded Stream Prefetcher

This block sits beside a second-level cache and watches the demand traffic that reaches it: instruction fetches, data reads and reads-for-ownership. It keeps a table of sixteen streams. Each stream follows one 4 KB page and records the last line index it saw and the sign of the last small step. When two steps in a row point the same way, the stream counts as trained. The block then issues a short burst of line prefetches that runs ahead of the demand pointer.

A burst holds at most four consecutive lines and never leaves the page, with one exception. When fewer than four lines remain before the page edge, the burst covers the remaining lines of the page and then one line in the adjacent page. The stream is then moved to that adjacent page so it can keep going there. Instruction streams always run forward. Each prefetch carries the kind of the demand access that started it. Requests leave on a valid/ready port, and a single generator holds one burst at a time.

Top module: `stream_prefetcher`

## Requirements
- R1: After reset `pf_valid` is 0 and no stream is tracked, so demand traffic alone produces no prefetch until a stream has been allocated and trained.
- R2: A stream is allocated only by an access with `acc_miss`=1 whose page (`acc_addr[31:12]`) no entry tracks. Accesses with `acc_miss`=0 to an untracked page allocate nothing and produce no prefetch.
- R3: Line index is `acc_addr[11:6]`. The delta is the new index minus the stored index. A delta of 0 changes nothing. A nonzero delta in the range -4..+4 trains the stream when the previous delta was also in range and had the same sign. A delta outside the range clears the stored sign, so two new same-sign steps are needed.
- R4: A trained access starts a burst of consecutive 64-byte lines, beginning one line past the triggering line in the stream direction (positive delta is forward). The burst holds four lines when at least four lines remain in the page in that direction.
- R5: For instruction fetches (kind 00), the burst always runs forward (increasing addresses), whatever the sign of the training deltas.
- R6: When only r<4 lines remain before the page edge, the burst holds r in-page lines plus one line in the adjacent page: line 0 of the next page going forward, line 63 of the previous page going backward. The stream then tracks the adjacent page, with the edge line stored as its last index and its sign kept. The move is skipped if another entry already tracks that page.
- R7: Kind encoding is 00 instruction fetch, 01 read, 10 read-for-ownership. Every prefetch carries, on `pf_kind`, the kind of the access that triggered its burst.
- R8: `pf_addr` is always a line address, with bits [5:0] equal to zero.
- R9: With all 16 entries valid, a new allocation replaces the least-recently-used entry. Both a hit and an allocation count as a use.
- R10: While `pf_valid`=1 and `pf_ready`=0, `pf_valid`, `pf_addr` and `pf_kind` hold their values.
- R11: A trained access that arrives while a burst is still outstanding starts no burst. It is not queued, and the outstanding burst runs to its full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Demand access present this cycle |
| acc_addr | input | 32 | Demand byte address |
| acc_kind | input | 2 | Access kind: 00 fetch, 01 read, 10 read-for-ownership |
| acc_miss | input | 1 | The access missed the cache |
| pf_valid | output | 1 | Prefetch request valid |
| pf_ready | input | 1 | Downstream accepts the request |
| pf_addr | output | 32 | Prefetch line address |
| pf_kind | output | 2 | Kind carried by the prefetch |

## Verification
The assertions assume that `acc_kind` never takes the value 11. The bench drives only the three defined kinds. The assertions also assume that `pf_ready` is a plain input that may stay low for any number of cycles. The bench holds it low across a whole training sequence to cover both the stall-hold rule and the dropped trigger. The step checks assume no backward stream reaches page 0 and no forward stream reaches the top page. The bench keeps every stream in mid-range pages so that no burst wraps around the address space.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  // demand / prefetch kind encoding
  localparam logic [1:0] KIND_CODE = 2'b00;
  localparam logic [1:0] KIND_READ = 2'b01;
  localparam logic [1:0] KIND_RFO  = 2'b10;
endpackage

// File: rtl/pfx_stream_table.sv
module pfx_stream_table
  import pfx_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int N         = 16,
  parameter int LINE_BITS = 6,
  parameter int PAGE_BITS = 12,
  parameter int DEPTH     = 4,
  parameter int WIN       = 4,
  localparam int LA_W     = ADDR_W - LINE_BITS,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [LA_W-1:0]  acc_line,
  input  logic [1:0]       acc_kind,
  input  logic             acc_miss,
  input  logic             gen_idle,
  output logic             launch,
  output logic [LA_W-1:0]  launch_line,
  output logic [CNT_W-1:0] launch_cnt,
  output logic             launch_fwd,
  output logic [1:0]       launch_kind,
  output logic [N-1:0]     hit_vec,
  output logic             alloc
);
  localparam int PG_W  = ADDR_W - PAGE_BITS;
  localparam int LI_W  = PAGE_BITS - LINE_BITS;
  localparam int IDX_W = $clog2(N);
  localparam logic [LI_W-1:0]        EDGE_LI = '1;
  localparam logic [LI_W-1:0]        DEPTH_LI = LI_W'(DEPTH);
  localparam logic signed [LI_W:0]   WIN_S = (LI_W+1)'(WIN);
  localparam logic [IDX_W-1:0]       OLDEST = IDX_W'(N - 1);

  logic              vld_q [N];
  logic [PG_W-1:0]   pg_q  [N];
  logic [LI_W-1:0]   lst_q [N];
  logic              sgn_q [N];
  logic              sgv_q [N];
  logic [IDX_W-1:0]  age_q [N];

  function automatic logic signed [LI_W:0] delta_of(input logic [LI_W-1:0] now_li,
                                                     input logic [LI_W-1:0] was_li);
    return $signed({1'b0, now_li}) - $signed({1'b0, was_li});
  endfunction

  function automatic logic [LI_W-1:0] room_of(input logic [LI_W-1:0] li, input logic fwd);
    return fwd ? (EDGE_LI - li) : li;
  endfunction

  function automatic logic [CNT_W-1:0] len_of(input logic [LI_W-1:0] room);
    if (room >= DEPTH_LI) return CNT_W'(DEPTH);
    return CNT_W'(room) + CNT_W'(1);
  endfunction

  logic [PG_W-1:0]     acc_pg;
  logic [LI_W-1:0]     acc_li;
  logic                hit_any, free_any, tgt_taken, in_win, pos, move;
  logic [IDX_W-1:0]    hit_idx, free_idx, old_idx, victim, touch_idx;
  logic signed [LI_W:0] dlt;
  logic [LI_W-1:0]     room;
  logic [PG_W-1:0]     tgt_pg;
  logic                touch;

  assign acc_pg = acc_line[LA_W-1:LI_W];
  assign acc_li = acc_line[LI_W-1:0];

  always_comb begin
    hit_any  = 1'b0; hit_idx  = '0;
    free_any = 1'b0; free_idx = '0;
    old_idx  = '0;
    for (int i = 0; i < N; i++) begin
      hit_vec[i] = vld_q[i] && (pg_q[i] == acc_pg);
      if (hit_vec[i] && !hit_any) begin hit_any = 1'b1; hit_idx = IDX_W'(i); end
      if (!vld_q[i] && !free_any) begin free_any = 1'b1; free_idx = IDX_W'(i); end
      if (age_q[i] == OLDEST) old_idx = IDX_W'(i);
    end
  end

  assign dlt        = delta_of(acc_li, lst_q[hit_idx]);
  assign in_win     = (dlt != '0) && (dlt <= WIN_S) && (dlt >= -WIN_S);
  assign pos        = !dlt[LI_W];
  assign launch_fwd = (acc_kind == KIND_CODE) ? 1'b1 : pos;
  assign room       = room_of(acc_li, launch_fwd);
  assign tgt_pg     = launch_fwd ? (acc_pg + PG_W'(1)) : (acc_pg - PG_W'(1));

  always_comb begin
    tgt_taken = 1'b0;
    for (int i = 0; i < N; i++)
      if (vld_q[i] && (pg_q[i] == tgt_pg)) tgt_taken = 1'b1;
  end

  assign launch      = acc_valid && hit_any && in_win && sgv_q[hit_idx]
                       && (sgn_q[hit_idx] == pos) && gen_idle;
  assign launch_cnt  = len_of(room);
  assign launch_line = launch_fwd ? (acc_line + LA_W'(1)) : (acc_line - LA_W'(1));
  assign launch_kind = acc_kind;
  assign move        = launch && (room < DEPTH_LI) && !tgt_taken;

  assign alloc     = acc_valid && !hit_any && acc_miss;
  assign victim    = free_any ? free_idx : old_idx;
  assign touch     = (acc_valid && hit_any) || alloc;
  assign touch_idx = hit_any ? hit_idx : victim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        vld_q[i] <= 1'b0; pg_q[i] <= '0; lst_q[i] <= '0;
        sgn_q[i] <= 1'b0; sgv_q[i] <= 1'b0; age_q[i] <= IDX_W'(i);
      end
    end else begin
      if (touch) begin
        for (int i = 0; i < N; i++) begin
          if (IDX_W'(i) == touch_idx)            age_q[i] <= '0;
          else if (age_q[i] < age_q[touch_idx])  age_q[i] <= age_q[i] + IDX_W'(1);
        end
      end
      if (alloc) begin
        vld_q[victim] <= 1'b1;
        pg_q[victim]  <= acc_pg;
        lst_q[victim] <= acc_li;
        sgn_q[victim] <= 1'b0;
        sgv_q[victim] <= 1'b0;
      end else if (acc_valid && hit_any) begin
        if (move) begin
          pg_q[hit_idx]  <= tgt_pg;
          lst_q[hit_idx] <= launch_fwd ? '0 : EDGE_LI;
        end else begin
          lst_q[hit_idx] <= acc_li;
        end
        if (in_win) begin
          sgn_q[hit_idx] <= pos;
          sgv_q[hit_idx] <= 1'b1;
        end else if (dlt != '0) begin
          sgv_q[hit_idx] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/pfx_burst_gen.sv
module pfx_burst_gen #(
  parameter int ADDR_W    = 32,
  parameter int LINE_BITS = 6,
  parameter int DEPTH     = 4,
  localparam int LA_W     = ADDR_W - LINE_BITS,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [LA_W-1:0]  launch_line,
  input  logic [CNT_W-1:0] launch_cnt,
  input  logic             launch_fwd,
  input  logic [1:0]       launch_kind,
  input  logic             pf_ready,
  output logic             pf_valid,
  output logic [ADDR_W-1:0] pf_addr,
  output logic [1:0]       pf_kind,
  output logic             idle
);
  logic             busy_q, fwd_q;
  logic [LA_W-1:0]  cur_q;
  logic [CNT_W-1:0] rem_q;
  logic [1:0]       kind_q;

  function automatic logic [LA_W-1:0] step_line(input logic [LA_W-1:0] ln, input logic fwd);
    return fwd ? (ln + LA_W'(1)) : (ln - LA_W'(1));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0; fwd_q <= 1'b1; cur_q <= '0; rem_q <= '0; kind_q <= '0;
    end else if (launch) begin
      busy_q <= 1'b1;
      cur_q  <= launch_line;
      rem_q  <= launch_cnt;
      fwd_q  <= launch_fwd;
      kind_q <= launch_kind;
    end else if (busy_q && pf_ready) begin
      cur_q <= step_line(cur_q, fwd_q);
      rem_q <= rem_q - CNT_W'(1);
      if (rem_q == CNT_W'(1)) busy_q <= 1'b0;
    end
  end

  assign pf_valid = busy_q;
  assign pf_addr  = {cur_q, {LINE_BITS{1'b0}}};
  assign pf_kind  = kind_q;
  assign idle     = !busy_q;
endmodule

// File: rtl/stream_prefetcher.sv
module stream_prefetcher #(
  parameter int ADDR_W      = 32,
  parameter int NUM_STREAMS = 16,
  parameter int LINE_BITS   = 6,
  parameter int PAGE_BITS   = 12,
  parameter int DEPTH       = 4,
  parameter int WIN         = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_kind,
  input  logic              acc_miss,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr,
  output logic [1:0]        pf_kind
);
  localparam int LA_W  = ADDR_W - LINE_BITS;
  localparam int CNT_W = $clog2(DEPTH + 1);

  // named internal events, observed by the bound checker
  logic                   launch_w, fwd_w, idle_w, alloc_w;
  logic [LA_W-1:0]        line_w;
  logic [CNT_W-1:0]       cnt_w;
  logic [1:0]             kind_w;
  logic [NUM_STREAMS-1:0] hit_vec_w;
  logic                   unused_offset;

  assign unused_offset = ^acc_addr[LINE_BITS-1:0];

  pfx_stream_table #(
    .ADDR_W(ADDR_W), .N(NUM_STREAMS), .LINE_BITS(LINE_BITS),
    .PAGE_BITS(PAGE_BITS), .DEPTH(DEPTH), .WIN(WIN)
  ) table_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid),
    .acc_line(acc_addr[ADDR_W-1:LINE_BITS]), .acc_kind(acc_kind), .acc_miss(acc_miss),
    .gen_idle(idle_w), .launch(launch_w), .launch_line(line_w), .launch_cnt(cnt_w),
    .launch_fwd(fwd_w), .launch_kind(kind_w), .hit_vec(hit_vec_w), .alloc(alloc_w)
  );

  pfx_burst_gen #(
    .ADDR_W(ADDR_W), .LINE_BITS(LINE_BITS), .DEPTH(DEPTH)
  ) gen_i (
    .clk(clk), .rst_n(rst_n), .launch(launch_w), .launch_line(line_w),
    .launch_cnt(cnt_w), .launch_fwd(fwd_w), .launch_kind(kind_w), .pf_ready(pf_ready),
    .pf_valid(pf_valid), .pf_addr(pf_addr), .pf_kind(pf_kind), .idle(idle_w)
  );
endmodule

// File: rtl/pfx_checker.sv
module pfx_checker #(
  parameter int ADDR_W    = 32,
  parameter int LINE_BITS = 6,
  parameter int N         = 16,
  parameter int DEPTH     = 4,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pf_valid,
  input logic              pf_ready,
  input logic [ADDR_W-1:0] pf_addr,
  input logic [1:0]        pf_kind,
  input logic              launch,
  input logic [CNT_W-1:0]  launch_cnt,
  input logic [N-1:0]      hit_vec,
  input logic              alloc,
  input logic              acc_valid
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << LINE_BITS;

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr) && $stable(pf_kind));

  // R8
  line_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> pf_addr[LINE_BITS-1:0] == '0);

  // R4
  line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && pf_ready |=> !pf_valid || (pf_addr == $past(pf_addr) + STEP)
                             || (pf_addr == $past(pf_addr) - STEP));

  // R5
  code_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && pf_ready && pf_kind == 2'b00 |=> !pf_valid || (pf_addr == $past(pf_addr) + STEP));

  // R7
  kind_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && pf_ready |=> !pf_valid || $stable(pf_kind));

  // R11
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !pf_valid);

  // R4
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> (launch_cnt != '0) && (launch_cnt <= CNT_W'(DEPTH)));

  // R2
  one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R2
  alloc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> acc_valid && !launch);

  // R6
  launch_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> pf_valid);
endmodule

bind stream_prefetcher pfx_checker #(
  .ADDR_W(ADDR_W), .LINE_BITS(LINE_BITS), .N(NUM_STREAMS), .DEPTH(DEPTH)
) chk_i (
  .clk(clk), .rst_n(rst_n), .pf_valid(pf_valid), .pf_ready(pf_ready),
  .pf_addr(pf_addr), .pf_kind(pf_kind), .launch(launch_w), .launch_cnt(cnt_w),
  .hit_vec(hit_vec_w), .alloc(alloc_w), .acc_valid(acc_valid)
);

// File: tb/stream_prefetcher_tb_top.sv
`timescale 1ns/1ps
module stream_prefetcher_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, acc_valid, acc_miss, pf_valid, pf_ready;
  logic [31:0] acc_addr, pf_addr;
  logic [1:0]  acc_kind, pf_kind;

  always #2.5 clk = ~clk;

  stream_prefetcher dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_kind(acc_kind), .acc_miss(acc_miss), .pf_valid(pf_valid),
    .pf_ready(pf_ready), .pf_addr(pf_addr), .pf_kind(pf_kind)
  );

  int          n_chk = 0, n_bad = 0, got_n = 0;
  bit          done = 1'b0;
  logic [31:0] got_a [64];
  logic [1:0]  got_k [64];

  // record every accepted prefetch, sampled mid-cycle
  always @(negedge clk)
    if (rst_n && pf_valid && pf_ready && got_n < 64) begin
      got_a[got_n] = pf_addr;
      got_k[got_n] = pf_kind;
      got_n++;
    end

  function automatic logic [31:0] mk(input int page, input int line);
    return (32'(page) << 12) | (32'(line) << 6);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; acc_valid = 1'b0; acc_miss = 1'b0; acc_addr = '0;
    acc_kind = 2'b01; pf_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    got_n = 0;
  endtask

  task automatic acc(input int page, input int line, input logic [1:0] kind, input bit miss);
    @(posedge clk); #1;
    acc_valid = 1'b1; acc_addr = mk(page, line) | 32'h15; acc_kind = kind; acc_miss = miss;
    @(posedge clk); #1;
    acc_valid = 1'b0; acc_miss = 1'b0;
  endtask

  task automatic drain();
    pf_ready = 1'b1;
    repeat (12) @(posedge clk);
    #1;
  endtask

  // expected burst: walk away from the trigger line, stop after 4 or after leaving the page
  task automatic expect_burst(input int page, input int line, input bit fwd,
                              input logic [1:0] kind, input string req);
    int base, n;
    logic [31:0] exp_a [8];
    base = page * 64 + line;
    n = 0;
    for (int k = 1; k <= 4; k++) begin
      int nx;
      nx = fwd ? base + k : base - k;
      exp_a[n] = 32'(nx) << 6;
      n++;
      if ((nx / 64) != (base / 64)) break;
    end
    chk(got_n == n, {req, " count"}, 32'(got_n), 32'(n));
    for (int i = 0; i < n && i < got_n; i++) begin
      chk(got_a[i] == exp_a[i], {req, " addr"}, got_a[i], exp_a[i]);
      chk(got_k[i] == kind, {req, " kind R7"}, 32'(got_k[i]), 32'(kind));
    end
    got_n = 0;
  endtask

  task automatic t_reset_state();
    chk(pf_valid == 1'b0, "R1 reset valid", 32'(pf_valid), 0);
    acc(8, 0, 2'b01, 0); acc(8, 1, 2'b01, 0); acc(8, 2, 2'b01, 0); acc(8, 3, 2'b01, 0);
    drain();
    chk(got_n == 0, "R2 no-miss allocates nothing", 32'(got_n), 0);
    got_n = 0;
  endtask

  task automatic t_forward();
    acc(16, 8, 2'b01, 1); acc(16, 9, 2'b01, 0); acc(16, 10, 2'b01, 0);
    drain();
    expect_burst(16, 10, 1, 2'b01, "R4 forward read");
  endtask

  task automatic t_backward();
    acc(32, 40, 2'b10, 1); acc(32, 38, 2'b10, 0); acc(32, 36, 2'b10, 0);
    drain();
    expect_burst(32, 36, 0, 2'b10, "R4 backward rfo");
  endtask

  task automatic t_window();
    acc(48, 10, 2'b01, 1); acc(48, 15, 2'b01, 0); acc(48, 16, 2'b01, 0); acc(48, 16, 2'b01, 0);
    drain();
    chk(got_n == 0, "R3 big step and zero step do not train", 32'(got_n), 0);
    acc(48, 17, 2'b01, 0);
    drain();
    expect_burst(48, 17, 1, 2'b01, "R3 trained after two +1");
    acc(49, 10, 2'b01, 1); acc(49, 11, 2'b01, 0); acc(49, 9, 2'b01, 0);
    drain();
    chk(got_n == 0, "R3 sign flip does not train", 32'(got_n), 0);
    acc(49, 8, 2'b01, 0);
    drain();
    expect_burst(49, 8, 0, 2'b01, "R3 trained after two negative");
    acc(50, 10, 2'b01, 1); acc(50, 11, 2'b01, 0); acc(50, 20, 2'b01, 0); acc(50, 21, 2'b01, 0);
    drain();
    chk(got_n == 0, "R3 out-of-window step restarts", 32'(got_n), 0);
    acc(50, 22, 2'b01, 0);
    drain();
    expect_burst(50, 22, 1, 2'b01, "R3 retrained after restart");
  endtask

  task automatic t_code();
    acc(64, 20, 2'b00, 1); acc(64, 18, 2'b00, 0); acc(64, 16, 2'b00, 0);
    drain();
    expect_burst(64, 16, 1, 2'b00, "R5 code forced forward");
  endtask

  task automatic t_boundary();
    acc(80, 58, 2'b01, 1); acc(80, 59, 2'b01, 0); acc(80, 60, 2'b01, 0);
    drain();
    expect_burst(80, 60, 1, 2'b01, "R6 forward edge");
    acc(81, 1, 2'b01, 0);
    drain();
    expect_burst(81, 1, 1, 2'b01, "R6 stream moved to next page");
    acc(96, 5, 2'b10, 1); acc(96, 4, 2'b10, 0); acc(96, 3, 2'b10, 0);
    drain();
    expect_burst(96, 3, 0, 2'b10, "R6 backward edge");
  endtask

  task automatic t_stall();
    pf_ready = 1'b0;
    acc(112, 0, 2'b01, 1); acc(112, 1, 2'b01, 0); acc(112, 2, 2'b01, 0);
    @(posedge clk); #1;
    chk(pf_valid == 1'b1, "R10 valid while stalled", 32'(pf_valid), 1);
    chk(pf_addr == mk(112, 3), "R10 addr while stalled", pf_addr, mk(112, 3));
    acc(113, 0, 2'b01, 1); acc(113, 1, 2'b01, 0); acc(113, 2, 2'b01, 0);
    repeat (4) @(posedge clk); #1;
    chk(pf_valid == 1'b1, "R10 valid held", 32'(pf_valid), 1);
    chk(pf_addr == mk(112, 3), "R10 addr held", pf_addr, mk(112, 3));
    chk(pf_kind == 2'b01, "R10 kind held", 32'(pf_kind), 1);
    drain();
    expect_burst(112, 2, 1, 2'b01, "R11 busy trigger dropped");
  endtask

  task automatic t_lru();
    do_reset();
    for (int p = 0; p < 16; p++) acc(256 + p, 0, 2'b01, 1);
    acc(256, 0, 2'b01, 0);
    acc(272, 0, 2'b01, 1);
    acc(257, 0, 2'b01, 0); acc(257, 1, 2'b01, 0); acc(257, 2, 2'b01, 0);
    drain();
    chk(got_n == 0, "R9 oldest page evicted", 32'(got_n), 0);
    got_n = 0;
    acc(256, 1, 2'b01, 0); acc(256, 2, 2'b01, 0);
    drain();
    expect_burst(256, 2, 1, 2'b01, "R9 touched page kept");
    acc(272, 1, 2'b01, 0); acc(272, 2, 2'b01, 0);
    drain();
    expect_burst(272, 2, 1, 2'b01, "R9 new page tracked");
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_forward();
    t_backward();
    t_window();
    t_code();
    t_boundary();
    t_stall();
    t_lru();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule